// File: doc/BRIEF.md
# Protected Memory-Mode Control Register with Address-Area Decoder

This block holds the 8-bit processor memory-mode configuration of a small controller and turns it, together with the current processor-mode field, into a classification of every 20-bit access address. A bus master writes the register through a plain strobe-and-data port. The write lands only while a separate protect-enable input is high. A flash rewrite-mode flag forces two configuration bits high for as long as it is set. When the flag drops, the stored values show again.

The decoder is purely combinational. It reports whether the address falls in internal RAM, internal ROM, the external chip-select-2 window, the general external space, or a reserved hole. When the wait-enable bit is set, it raises a wait request for every internal access. All pins are control or status signals that are sampled or presented every cycle, so there is no valid/ready handshake and no back-pressure: a write strobe is consumed in the cycle it is seen.

Top module: `mm_mode_unit`

## Requirements
- R1: After reset, `mode_rd` reads 0x08 while `rewrite_mode` is 0.
- R2: A write updates the register at a rising clock edge only when `wr_stb` and `prot_en` are both 1. A strobe with `prot_en` at 0 leaves `mode_rd` unchanged.
- R3: Bit 0 (chip-select-2 late start), bit 1 (port function), bit 3 (area expansion) and bit 7 (wait enable) take the written value. Bit 6 always reads 0.
- R4: Bit 2 (watchdog action) is set by writing 1. Writing 0 leaves it at 1. Only reset clears it.
- R5: While `rewrite_mode` is 1, bits 0 and 3 of `mode_rd` read 1, and decoding uses those forced values. When the flag returns to 0, the stored bits are seen again.
- R6: Bits 5:4 (memory size) accept 00 and 11. A write carrying 01 or 10 leaves their previous value.
- R7: `area` codes are 0 reserved, 1 internal RAM, 2 internal ROM, 3 chip-select-2, 4 general external. With bit 3 at 0, RAM is 0x00400–0x03FFF and ROM is 0xD0000–0xFFFFF. With bit 3 at 1, RAM is 0x00400–0x07FFF and ROM is 0x80000–0xFFFFF. 0x00000–0x003FF is always reserved.
- R8: With bit 0 at 1, 0x0F000–0x0FFFF decodes as internal ROM in every processor mode.
- R9: In processor modes 01 and 11, chip-select-2 covers 0x08000–0x26FFF when bit 0 is 0, and 0x10000–0x26FFF when bit 0 is 1. With bit 0 at 1, 0x08000–0x0EFFF is general external.
- R10: In processor modes 01 and 11, 0x27000–0x7FFFF is general external. With bit 3 at 0, 0x04000–0x07FFF and 0x80000–0xCFFFF are general external too. In modes 00 and 10, every address outside the internal areas decodes as reserved.
- R11: `wait_req` equals bit 7 of `mode_rd` ANDed with the area being internal RAM or ROM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| prot_en | input | 1 | Write-protect release; writes only land while 1 |
| rewrite_mode | input | 1 | Flash rewrite-mode flag; forces bits 0 and 3 |
| proc_mode | input | 2 | Processor-mode field; 01 and 11 enable external decoding |
| acc_addr | input | 20 | Access address to classify |
| mode_rd | output | 8 | Effective register value |
| area | output | 3 | Area code of `acc_addr` |
| wait_req | output | 1 | One-wait request for internal accesses |

## Verification
Every window edge is probed as a pair of addresses, the last address of one area and the first of the next. This is done for all combinations of the expansion bit, the chip-select start bit and the four processor modes, which exposes off-by-one limits and mode leakage. The register is hit with writes that alternate with and without protect release, with attempts to clear the sticky bit, and with illegal size codes. This separates the gating, stickiness and hold-previous rules. Rewrite mode is toggled under random traffic, which shows whether the forced bits come from the read path or get written into storage.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int AW   = 20;
  localparam int RW   = 8;
  localparam int AREA_W = 3;

  typedef logic [AW-1:0] addr_t;

  typedef enum logic [AREA_W-1:0] {
    AREA_RSVD = 3'd0,
    AREA_RAM  = 3'd1,
    AREA_ROM  = 3'd2,
    AREA_CS2  = 3'd3,
    AREA_EXT  = 3'd4
  } area_e;

  // register bit positions (software visible)
  localparam int B_CS2LATE = 0;
  localparam int B_WDRST   = 2;
  localparam int B_EXPAND  = 3;
  localparam int B_SZLO    = 4;
  localparam int B_SZHI    = 5;
  localparam int B_RSV     = 6;
  localparam int B_WAIT    = 7;

  localparam logic [RW-1:0] CFG_RESET  = 8'h08;
  localparam logic [RW-1:0] STICKY_MSK = 8'h04;
  localparam logic [RW-1:0] ZERO_MSK   = 8'h40;
  localparam logic [RW-1:0] SIZE_MSK   = 8'h30;
  localparam logic [RW-1:0] FORCE_MSK  = 8'h09;

  // window limits
  localparam addr_t LIM_SFR_END  = 20'h003FF;
  localparam addr_t LIM_RAM_NRM  = 20'h03FFF;
  localparam addr_t LIM_RAM_EXP  = 20'h07FFF;
  localparam addr_t LIM_CS2_EARLY = 20'h08000;
  localparam addr_t LIM_BLKA_LO  = 20'h0F000;
  localparam addr_t LIM_CS2_LATE = 20'h10000;
  localparam addr_t LIM_CS2_END  = 20'h26FFF;
  localparam addr_t LIM_ROM_EXP  = 20'h80000;
  localparam addr_t LIM_ROM_NRM  = 20'hD0000;
endpackage

// File: rtl/mm_cfg_reg.sv
module mm_cfg_reg
  import mm_pkg::*;
#(
  parameter int W = RW,
  parameter logic [W-1:0] RST_VAL = CFG_RESET,
  parameter logic [W-1:0] STICKY  = STICKY_MSK,
  parameter logic [W-1:0] ZEROS   = ZERO_MSK,
  parameter logic [W-1:0] PAIRED  = SIZE_MSK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // paired field accepts only uniform codes (all zero or all one)
  logic [W-1:0] pair_bits;
  logic         pair_ok;
  assign pair_bits = d & PAIRED;
  assign pair_ok   = (pair_bits == '0) || (pair_bits == PAIRED);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bq;
    if (ZEROS[i]) begin : g_zero
      assign bq = 1'b0;
    end else if (STICKY[i]) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  bq <= RST_VAL[i];
        else if (we) bq <= bq | d[i];
      end
    end else if (PAIRED[i]) begin : g_pair
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             bq <= RST_VAL[i];
        else if (we && pair_ok) bq <= d[i];
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  bq <= RST_VAL[i];
        else if (we) bq <= d[i];
      end
    end
    assign q[i] = bq;
  end
endmodule

// File: rtl/mm_area_dec.sv
module mm_area_dec
  import mm_pkg::*;
(
  input  addr_t addr,
  input  logic  cs2_late,
  input  logic  expand,
  input  logic  ext_mode,
  output area_e area
);
  logic in_sfr, in_ram_lo, in_mid, in_gap8, in_blka, in_cs2hi, in_ext, in_romexp;
  area_e far_kind;

  always_comb begin
    in_sfr    = addr <= LIM_SFR_END;
    in_ram_lo = addr <= LIM_RAM_NRM;
    in_mid    = addr <= LIM_RAM_EXP;
    in_gap8   = addr < LIM_CS2_LATE;
    in_blka   = addr >= LIM_BLKA_LO;
    in_cs2hi  = addr <= LIM_CS2_END;
    in_ext    = addr < LIM_ROM_EXP;
    in_romexp = addr < LIM_ROM_NRM;
    far_kind  = ext_mode ? AREA_EXT : AREA_RSVD;

    if (in_sfr)             area = AREA_RSVD;
    else if (in_ram_lo)     area = AREA_RAM;
    else if (in_mid)        area = expand ? AREA_RAM : far_kind;
    else if (in_gap8) begin
      if (cs2_late && in_blka) area = AREA_ROM;
      else if (!ext_mode)      area = AREA_RSVD;
      else                     area = cs2_late ? AREA_EXT : AREA_CS2;
    end
    else if (in_cs2hi)      area = ext_mode ? AREA_CS2 : AREA_RSVD;
    else if (in_ext)        area = far_kind;
    else if (in_romexp)     area = expand ? AREA_ROM : far_kind;
    else                    area = AREA_ROM;
  end
endmodule

// File: rtl/mm_mode_unit.sv
module mm_mode_unit
  import mm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [RW-1:0] wr_data,
  input  logic          prot_en,
  input  logic          rewrite_mode,
  input  logic [1:0]    proc_mode,
  input  logic [AW-1:0] acc_addr,
  output logic [RW-1:0] mode_rd,
  output logic [AREA_W-1:0] area,
  output logic          wait_req
);
  logic [RW-1:0] cfg_q;
  logic [RW-1:0] cfg_eff;
  logic          ext_mode;
  area_e         area_k;

  mm_cfg_reg u_reg (
    .clk (clk),
    .rst_n (rst_n),
    .we  (wr_stb & prot_en),
    .d   (wr_data),
    .q   (cfg_q)
  );

  assign cfg_eff  = cfg_q | (rewrite_mode ? FORCE_MSK : '0);
  assign ext_mode = proc_mode[0];

  mm_area_dec u_dec (
    .addr     (acc_addr),
    .cs2_late (cfg_eff[B_CS2LATE]),
    .expand   (cfg_eff[B_EXPAND]),
    .ext_mode (ext_mode),
    .area     (area_k)
  );

  assign mode_rd  = cfg_eff;
  assign area     = area_k;
  assign wait_req = cfg_eff[B_WAIT] & ((area_k == AREA_RAM) | (area_k == AREA_ROM));
endmodule

// File: rtl/mm_mode_chk.sv
module mm_mode_chk
  import mm_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_stb,
  input logic          prot_en,
  input logic          rewrite_mode,
  input logic [1:0]    proc_mode,
  input logic [RW-1:0] cfg_q,
  input logic [RW-1:0] mode_rd,
  input logic [AREA_W-1:0] area,
  input logic          wait_req
);
  AST_PROTECTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !prot_en) |=> (cfg_q == $past(cfg_q))); // R2
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[B_WDRST] |=> cfg_q[B_WDRST]); // R4
  AST_REWRITE_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    rewrite_mode |-> (mode_rd[B_CS2LATE] && mode_rd[B_EXPAND])); // R5
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rd[B_SZHI] == mode_rd[B_SZLO]); // R6
  AST_WAIT_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    wait_req |-> (area == AREA_RAM || area == AREA_ROM)); // R11
  AST_SINGLE_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    !proc_mode[0] |-> (area != AREA_CS2 && area != AREA_EXT)); // R10
endmodule

bind mm_mode_unit mm_mode_chk u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .wr_stb (wr_stb),
  .prot_en (prot_en),
  .rewrite_mode (rewrite_mode),
  .proc_mode (proc_mode),
  .cfg_q (cfg_q),
  .mode_rd (mode_rd),
  .area (area),
  .wait_req (wait_req)
);

// File: tb/mm_mode_unit_test.sv
`timescale 1ns/1ps
module mm_mode_unit_test;
  logic clk = 0, rst_n = 0, wr_stb = 0, prot_en = 0, rewrite_mode = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] proc_mode = 0;
  logic [19:0] acc_addr = 0;
  logic [7:0] mode_rd;
  logic [2:0] area;
  logic wait_req;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m_q;

  always #5 clk = ~clk;

  mm_mode_unit uut (.clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .prot_en(prot_en), .rewrite_mode(rewrite_mode), .proc_mode(proc_mode),
    .acc_addr(acc_addr), .mode_rd(mode_rd), .area(area), .wait_req(wait_req));

  function automatic logic [7:0] nxt(input logic [7:0] m, input logic [7:0] d);
    logic [7:0] n;
    n = m;
    n[0] = d[0]; n[1] = d[1]; n[2] = m[2] | d[2]; n[3] = d[3];
    if (d[5] == d[4]) n[5:4] = d[5:4];
    n[6] = 1'b0; n[7] = d[7];
    return n;
  endfunction

  function automatic logic [7:0] eff(input logic [7:0] m, input logic rw);
    return rw ? (m | 8'h09) : m;
  endfunction

  // codes: 0 rsvd, 1 ram, 2 rom, 3 cs2, 4 ext
  function automatic logic [2:0] ref_area(input logic [19:0] a, input logic [7:0] e, input logic [1:0] pm);
    logic x, b0, xm;
    logic [2:0] far;
    x = e[3]; b0 = e[0]; xm = pm[0];
    far = xm ? 3'd4 : 3'd0;
    if (a < 20'h00400) return 3'd0;
    if (a < 20'h04000) return 3'd1;
    if (a < 20'h08000) return x ? 3'd1 : far;
    if (a < 20'h10000) begin
      if (b0 && a >= 20'h0F000) return 3'd2;
      if (!xm) return 3'd0;
      return b0 ? 3'd4 : 3'd3;
    end
    if (a < 20'h27000) return xm ? 3'd3 : 3'd0;
    if (a < 20'h80000) return far;
    if (a < 20'hD0000) return x ? 3'd2 : far;
    return 3'd2;
  endfunction

  task automatic chk_rd(input string tag);
    checks++;
    if (mode_rd !== eff(m_q, rewrite_mode)) begin
      errors++;
      $display("FAIL %s: mode_rd actual=%h expected=%h", tag, mode_rd, eff(m_q, rewrite_mode));
    end
  endtask

  task automatic chk_addr(input logic [19:0] a, input string tag);
    logic [2:0] ea;
    logic ew;
    @(negedge clk);
    acc_addr = a;
    #1;
    ea = ref_area(a, eff(m_q, rewrite_mode), proc_mode);
    ew = eff(m_q, rewrite_mode)[7] & (ea == 3'd1 || ea == 3'd2);
    checks++;
    if (area !== ea || wait_req !== ew) begin
      errors++;
      $display("FAIL %s: addr=%h pm=%b reg=%h area/wait actual=%0d/%b expected=%0d/%b",
               tag, a, proc_mode, mode_rd, area, wait_req, ea, ew);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic p, input string tag);
    @(negedge clk);
    wr_stb = 1; wr_data = d; prot_en = p;
    @(posedge clk);
    if (p) m_q = nxt(m_q, d);
    @(negedge clk);
    wr_stb = 0; prot_en = 0;
    chk_rd(tag);
  endtask

  localparam logic [19:0] EDGES [17] = '{20'h003FF, 20'h00400, 20'h03FFF, 20'h04000,
    20'h07FFF, 20'h08000, 20'h0EFFF, 20'h0F000, 20'h0FFFF, 20'h10000, 20'h26FFF,
    20'h27000, 20'h7FFFF, 20'h80000, 20'hCFFFF, 20'hD0000, 20'hFFFFF};

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_q = 8'h08;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk_rd("R1 reset value");
    // R2 protected write ignored
    wr(8'h81, 1'b0, "R2 blocked write");
    wr(8'hFF, 1'b1, "R3 R6 write all ones, R3 bit6 zero");
    wr(8'h00, 1'b1, "R4 sticky bit kept");
    wr(8'h10, 1'b1, "R6 illegal size 01");
    wr(8'h30, 1'b1, "R6 size 11");
    wr(8'h20, 1'b1, "R6 illegal size 10");
    wr(8'h00, 1'b0, "R2 blocked clear");
    // R5 rewrite forcing
    wr(8'h00, 1'b1, "R3 clear plain bits");
    @(negedge clk) rewrite_mode = 1; #1 chk_rd("R5 forced on");
    chk_addr(20'h0F000, "R5 R8 forced block A");
    chk_addr(20'h80000, "R5 R7 forced expand");
    @(negedge clk) rewrite_mode = 0; #1 chk_rd("R5 released");
    // boundary sweep
    for (int x = 0; x < 2; x++)
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < 2; w++) begin
          wr({w[0], 3'b000, x[0], 2'b00, b[0]}, 1'b1, "R3 setup");
          for (int pm = 0; pm < 4; pm++) begin
            proc_mode = pm[1:0];
            foreach (EDGES[k]) chk_addr(EDGES[k], "R7 R8 R9 R10 R11 edge");
          end
        end
    // random
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom_range(0, 3);
      if (op == 0) wr(8'($urandom), ($urandom_range(0, 9) < 7), "R2 R3 R4 R6 random write");
      else if (op == 1) begin
        @(negedge clk) rewrite_mode = $urandom_range(0, 1); #1 chk_rd("R5 random rewrite");
      end else if (op == 2) proc_mode = 2'($urandom);
      chk_addr(20'($urandom), "R7 R9 R10 R11 random addr");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule